// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. A sample enable that pulses eight times per bit period drives all timing. The character width, the parity mode and the stop count are set by plain configuration inputs, and they must match the far-end transmitter. Each finished character leaves through a valid/ready stream toward a receive FIFO, together with one error bit. That bit merges parity failures, low stop bits and break conditions, so a consumer cannot tell them apart.

The output stage holds a single character. `out_valid` rises when a character finishes and stays high, with `out_data` and `out_err` frozen, until a cycle in which `out_ready` is also high. If a new character finishes while the held one is still waiting, the new one is thrown away, the held one is kept, and `overrun` pulses for one clock. Handshake flow control is separate: `rts` permits the far end to send. It is forced high when `flow_en` is low. Otherwise it follows the FIFO occupancy reported on `fifo_level`.

Top module: `uart_rx8`

## Requirements
- R1: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives least significant bit first, and `out_data` bits above the selected width read zero.
- R2: A frame begins only on a high-to-low transition of the line that is still low at the fourth sample tick after it was seen. A shorter low pulse produces no character.
- R3: Each data, parity and stop bit is sampled once, at the fourth sample tick of its eight-tick period, counting from the tick that detected the start edge.
- R4: When `cfg_parity[2]` is 0, no parity bit is expected. When it is 1, `cfg_parity[1:0]` selects the parity rule: 0 = odd, 1 = mark (always 1), 2 = even, 3 = space (always 0). A parity bit that breaks the rule sets `out_err`, and the character is still delivered.
- R5: With `cfg_two_stop` at 0, one stop bit is checked. With it at 1, two stop bits are checked. Any stop bit sampled low sets `out_err`, and the character is still delivered.
- R6: A line held low for longer than a frame yields exactly one character, with data 0 and `out_err` 1. No further frame starts until the line has returned high.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_err` hold their values. A cycle with both at 1 clears `out_valid`.
- R8: A character that finishes while an earlier one is still held is dropped. `overrun` is 1 for exactly one clock, and the held character is unchanged.
- R9: `rts` is 1 whenever `flow_en` is 0. When `flow_en` is 1, `rts` is 1 exactly when `fifo_level` is below the parameter `RTS_LEVEL` (default 12).
- R10: After reset, `out_valid` and `overrun` are 0 and `rts` follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-clock enable, eight per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data width code |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| flow_en | input | 1 | Enables occupancy-driven `rts` |
| fifo_level | input | LVL_W (5) | Current receive FIFO occupancy |
| out_valid | output | 1 | Held character available |
| out_ready | input | 1 | Consumer accepts the held character |
| out_data | output | 8 | Received character, zero-extended |
| out_err | output | 1 | Merged parity, stop and break error |
| overrun | output | 1 | One-clock pulse when a character is dropped |
| rts | output | 1 | Far end may transmit |

## Verification
The hardest situation to reach from the ports is a break. The line must stay low through the stop-bit sample and beyond, and the receiver must then refuse to re-arm. The bench holds the line low for twelve bit times, accepts the single flagged character, and then watches for the long idle stretch that follows without a second one appearing. A rejected start is also hard to reach: a two-tick low pulse is driven, and a normal frame sent right after it must still arrive intact. Overrun is forced by leaving `out_ready` low across two full frames.

// File: rtl/uart_rx8_pkg.sv
package uart_rx8_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  // index of the last data bit for a width code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // expected parity bit for rule code and running xor of data
  function automatic logic want_parity(input logic [1:0] rule, input logic xr);
    case (rule)
      2'd0:    return ~xr;   // odd
      2'd1:    return 1'b1;  // mark
      2'd2:    return xr;    // even
      default: return 1'b0;  // space
    endcase
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx8_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        len,
  input  logic [2:0]        parity,
  input  logic              two_stop,
  output logic              done,
  output logic [CHAR_W-1:0] done_data,
  output logic              done_err
);
  localparam int PH_W     = $clog2(OSR);
  localparam int SAMPLE_PH = OSR / 2;

  rx_state_e         st;
  logic [PH_W-1:0]   ph;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              xr, err, last_hi;
  logic              at_sample;

  assign at_sample = (ph == PH_W'(SAMPLE_PH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; idx <= '0; shreg <= '0;
      xr <= 1'b0; err <= 1'b0; last_hi <= 1'b1;
      done <= 1'b0; done_data <= '0; done_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          last_hi <= line;
          if (last_hi && !line) begin
            st <= ST_START;
            ph <= '0;
          end
        end else begin
          ph <= (ph == PH_W'(OSR - 1)) ? '0 : ph + 1'b1;
          if (at_sample) begin
            case (st)
              ST_START: begin
                if (line) begin
                  st <= ST_IDLE;
                  last_hi <= 1'b1;
                end else begin
                  st <= ST_DATA; idx <= '0; shreg <= '0;
                  xr <= 1'b0; err <= 1'b0;
                end
              end
              ST_DATA: begin
                shreg[idx] <= line;
                xr <= xr ^ line;
                if (idx == last_bit_idx(len)) st <= parity[2] ? ST_PAR : ST_STOP1;
                else                          idx <= idx + 1'b1;
              end
              ST_PAR: begin
                if (line != want_parity(parity[1:0], xr)) err <= 1'b1;
                st <= ST_STOP1;
              end
              ST_STOP1: begin
                if (two_stop) begin
                  if (!line) err <= 1'b1;
                  st <= ST_STOP2;
                end else begin
                  st <= ST_IDLE; last_hi <= line; done <= 1'b1;
                  done_data <= shreg; done_err <= err | ~line;
                end
              end
              default: begin
                st <= ST_IDLE; last_hi <= line; done <= 1'b1;
                done_data <= shreg; done_err <= err | ~line;
              end
            endcase
          end
        end
      end
    end
  end

  // R2: entering the start state requires a low line on the detecting tick
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st) == ST_IDLE) |-> !$past(line));
  // R2: a start abandoned back to idle saw a high line at its check
  p_abort_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_START) |-> $past(line));
  // R3: a character completes only on a sample tick
  p_done_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick));
  // R6: one completion per frame
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_rx8.sv
module uart_rx8
  import uart_rx8_pkg::*;
#(
  parameter int OSR       = 8,
  parameter int LVL_W     = 5,
  parameter int RTS_LEVEL = 12,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              flow_en,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_err,
  output logic              overrun,
  output logic              rts
);
  logic              line_s;
  logic              f_done, f_err;
  logic [CHAR_W-1:0] f_data;

  rx_line_sync #(.STAGES(SYNC_FF)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  rx_frame_fsm #(.OSR(OSR)) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line_s),
    .len(cfg_len), .parity(cfg_parity), .two_stop(cfg_two_stop),
    .done(f_done), .done_data(f_data), .done_err(f_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_err <= 1'b0; overrun <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (f_done) begin
        if (out_valid && !out_ready) begin
          overrun <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= f_data;
          out_err   <= f_err;
        end
      end
    end
  end

  assign rts = !flow_en || (fifo_level < LVL_W'(RTS_LEVEL));

  // R7: a stalled character stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));
  // R8: dropping a character leaves the held one untouched
  p_ovr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (out_valid && $stable(out_data)));
  // R8: overrun lasts one clock
  p_ovr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
endmodule

// File: tb/uart_rx8_tb_top.sv
module uart_rx8_tb_top;
  localparam int CLK_NS = 8;
  localparam int BIT_CLK = 32;  // 8 ticks of 4 clocks
  localparam int NV = 14;
  // {len[2], par[3], two_stop, data[8], bad_par, bad_s1, bad_s2, exp_data[8], exp_err}
  localparam logic [25:0] VEC [0:NV-1] = '{
    {2'd3, 3'd0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0},
    {2'd0, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0},
    {2'd1, 3'd6, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h3F, 1'b0},
    {2'd2, 3'd4, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0},
    {2'd3, 3'd5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {2'd3, 3'd7, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0},
    {2'd3, 3'd6, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1},
    {2'd3, 3'd4, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1},
    {2'd3, 3'd5, 1'b0, 8'h12, 1'b1, 1'b0, 1'b0, 8'h12, 1'b1},
    {2'd3, 3'd0, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1},
    {2'd3, 3'd0, 1'b1, 8'h7E, 1'b0, 1'b0, 1'b1, 8'h7E, 1'b1},
    {2'd3, 3'd0, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 8'h7E, 1'b1},
    {2'd3, 3'd2, 1'b0, 8'h9A, 1'b0, 1'b0, 1'b0, 8'h9A, 1'b0},
    {2'd0, 3'd4, 1'b0, 8'h0A, 1'b0, 1'b0, 1'b0, 8'h0A, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_parity = 3'd0;
  logic cfg_two_stop = 1'b0, flow_en = 1'b0, out_ready = 1'b0;
  logic [4:0] fifo_level = 5'd0;
  logic out_valid, out_err, overrun, rts;
  logic [7:0] out_data;
  int checks = 0, fails = 0, ovr_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  uart_rx8 dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .flow_en(flow_en), .fifo_level(fifo_level), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
    .overrun(overrun), .rts(rts)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  end

  always @(posedge clk) if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v, input int nbits = 1);
    @(negedge clk) rxd = v;
    repeat (BIT_CLK * nbits - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] len, input logic [2:0] par, input logic s2,
                            input logic [7:0] d, input logic bp, input logic bs1,
                            input logic bs2);
    logic x, p;
    x = 1'b0;
    cfg_len = len; cfg_parity = par; cfg_two_stop = s2;
    bit_out(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) begin
      bit_out(d[i]);
      x ^= d[i];
    end
    if (par[2]) begin
      case (par[1:0])
        2'd0: p = ~x;
        2'd1: p = 1'b1;
        2'd2: p = x;
        default: p = 1'b0;
      endcase
      bit_out(p ^ bp);
    end
    bit_out(!bs1);
    if (s2) bit_out(!bs2);
    bit_out(1'b1);
  endtask

  task automatic accept();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10 valid after reset", out_valid, 0);
    check(overrun == 1'b0, "R10 overrun after reset", overrun, 0);
    check(rts == 1'b1, "R10 rts after reset", rts, 1);
    rst_n = 1'b1;
    bit_out(1'b1, 2);

    // table walk: R1 R3 R4 R5 R7
    for (int k = 0; k < NV; k++) begin
      send_frame(VEC[k][25:24], VEC[k][23:21], VEC[k][20], VEC[k][19:12],
                 VEC[k][11], VEC[k][10], VEC[k][9]);
      check(out_valid == 1'b1, "R3 character delivered", out_valid, 1);
      check(out_data == VEC[k][8:1], "R1 data", out_data, VEC[k][8:1]);
      check(out_err == VEC[k][0], "R4/R5 error flag", out_err, VEC[k][0]);
      repeat (7) @(negedge clk);
      check(out_valid && out_data == VEC[k][8:1], "R7 held while stalled", out_data, VEC[k][8:1]);
      accept();
      check(out_valid == 1'b0, "R7 cleared by handshake", out_valid, 0);
    end

    // R2: short low pulse rejected, following frame intact
    @(negedge clk) rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    bit_out(1'b1, 3);
    check(out_valid == 1'b0, "R2 glitch ignored", out_valid, 0);
    send_frame(2'd3, 3'd0, 1'b0, 8'h6B, 1'b0, 1'b0, 1'b0);
    check(out_valid && out_data == 8'h6B && !out_err, "R2 frame after glitch", out_data, 8'h6B);
    accept();

    // R6: break
    cfg_len = 2'd3; cfg_parity = 3'd0; cfg_two_stop = 1'b0;
    bit_out(1'b0, 12);
    check(out_valid && out_data == 8'h00 && out_err, "R6 break character",
          {out_valid, out_err, out_data}, 10'h300);
    accept();
    bit_out(1'b0, 4);
    bit_out(1'b1, 12);
    check(out_valid == 1'b0, "R6 no re-arm during break", out_valid, 0);

    // R8: overrun
    send_frame(2'd3, 3'd0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0);
    send_frame(2'd3, 3'd0, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0);
    check(ovr_cnt == 1, "R8 overrun pulse count", ovr_cnt, 1);
    check(out_valid && out_data == 8'h11, "R8 held character kept", out_data, 8'h11);
    accept();

    // R9: flow control
    fifo_level = 5'd31; flow_en = 1'b0;
    @(negedge clk) check(rts == 1'b1, "R9 rts without flow control", rts, 1);
    flow_en = 1'b1; fifo_level = 5'd11;
    @(negedge clk) check(rts == 1'b1, "R9 rts below level", rts, 1);
    fifo_level = 5'd12;
    @(negedge clk) check(rts == 1'b0, "R9 rts at level", rts, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule